// File: doc/BRIEF.md
# Punctured Register-Exchange Viterbi Decoder

This block decodes a continuous stream protected by a 64-state convolutional code whose mother code yields four parity bits for every information bit. On every clock it takes one trellis step: four 3-bit soft symbols, each with its own keep flag. A cleared flag marks a position that puncturing removed, and that position is treated as an erasure. All 64 path metrics are updated in the same cycle by add-compare-select. The metrics are kept bounded by subtracting a common offset. Survivors are held as 128-bit information-bit histories and are exchanged between states on every step.

The decoder never works in blocks. Once the pipeline has absorbed 128 steps it releases one decoded bit per clock. That bit is the oldest bit in the survivor of the state whose path metric is currently lowest. The upstream logic decides the puncturing pattern, performs any frame synchronisation and quantises the symbols; this block only needs the depunctured four-symbol step and the keep flags. Any rate between 8/9 and 1/4 is handled the same way.

Top module: `vit_dec_top`

## Requirements
- R1: Encoding convention. For step input u and previous state p (the last six inputs, newest in bit 0), parity bit j is the XOR of the bits selected by generator j in the 7-bit word {p, u}, where u is bit 0. The generators are octal 117, 127, 155 and 171 for j = 0..3. Soft symbol j sits in sym_i[3j+2:3j]. With error-free hard symbols (0 or 7) at full rate, bit_o after step c equals the information bit of step c-128, for random, all-ones and alternating inputs.
- R2: bit_vld_o is low for the first 127 clocks after reset is released and high from the 128th on. The first valid bit_o is the first information bit given after reset. bit_vld_o stays high until the next reset.
- R3: Path metrics never wrap. When the smallest metric reaches the threshold, every metric is lowered by that threshold. A run of 1500 noisy steps decodes without error.
- R4: A symbol whose keep_i bit is 0 adds nothing to any branch metric, whatever its value. The test pattern keeps symbol 0 on every step and symbol 1 on every eighth step (rate 8/9), with random values in the erased positions, and it decodes exactly.
- R5: The soft distance of a symbol r to an expected bit e is r when e is 0 and 7-r when e is 1. At rate 1/2, soft values within 2 of the ideal level decode correctly.
- R6: Reset is synchronous and active low. It clears bit_vld_o, gives state 0 a metric of 0 and every other state a large metric, and clears all survivors. Reset applied in mid-stream restarts the 128-step fill, and the stream that follows decodes from its own first bit.
- R7: At rate 1/4, decoding is error-free when symbol 2 is fully inverted once every 16 steps on top of soft noise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one trellis step per rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| sym_i | input | 12 | Four 3-bit soft symbols; symbol j at bits 3j+2..3j; 0 = confident zero, 7 = confident one |
| keep_i | input | 4 | Per-symbol keep flag; 0 marks an erasure |
| bit_o | output | 1 | Decoded information bit, 128 steps behind the input |
| bit_vld_o | output | 1 | High once 128 steps have been processed since reset |

## Verification
Clean full-rate streams of random, all-ones and alternating bits establish the encoding convention and the exact 128-step alignment of the output. The rate-8/9 pattern fills erased positions with random values, so any leakage of erasures into the metric shows up as decoding errors. Soft noise at rate 1/2 checks the soft distance. The 1500-step noisy run at rate 1/4 with periodic inverted symbols pushes the metrics well past the register width, so a faulty normalisation fails there. A second reset in mid-stream checks that the valid timing and the decoded sequence both restart.

// File: rtl/vit_pkg.sv
// vit_pkg: trellis constants and the parity function shared by the decoder.
// Assumes a feed-forward code whose generators all tap the current input.
package vit_pkg;
    localparam int K    = 7;
    localparam int MEM  = K - 1;
    localparam int NST  = 1 << MEM;
    localparam int NSYM = 4;
    localparam int NCW  = 1 << NSYM;
    localparam logic [NSYM-1:0][K-1:0] GEN = {7'o171, 7'o155, 7'o127, 7'o117};

    // Parity bits emitted when input u leaves state prev.
    function automatic logic [NSYM-1:0] code_word(input int unsigned prev, input logic u);
        logic [K-1:0]    reg_v;
        logic [NSYM-1:0] cw;
        reg_v = {prev[MEM-1:0], u};
        for (int j = 0; j < NSYM; j++) cw[j] = ^(GEN[j] & reg_v);
        return cw;
    endfunction
endpackage

// File: rtl/vit_bmu.sv
// vit_bmu: branch metric for every possible parity word of one step.
// Assumes soft symbols where 0 is a confident zero and all-ones a confident one.
// Erased symbols contribute nothing.
module vit_bmu import vit_pkg::*; #(
    parameter int SW  = 3,
    parameter int BMW = 5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NSYM*SW-1:0]   sym_i,
    input  logic [NSYM-1:0]      keep_i,
    output logic [BMW-1:0]       bm_o [NCW]
);
    localparam logic [SW-1:0] MAXV = '1;

    logic [BMW-1:0]  acc;
    logic [NSYM-1:0] cv;
    logic [SW-1:0]   r;

    // Sum the per-symbol distances of the kept symbols for each candidate word.
    always_comb begin
        acc = '0;
        cv  = '0;
        r   = '0;
        for (int c = 0; c < NCW; c++) begin
            cv  = NSYM'(c);
            acc = '0;
            for (int j = 0; j < NSYM; j++) begin
                r = sym_i[j*SW +: SW];
                if (keep_i[j]) acc = acc + BMW'(cv[j] ? (MAXV - r) : r);
            end
            bm_o[c] = acc;
        end
    end

    AST_ERASE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (keep_i == '0) |-> (bm_o[NCW-1] == '0 && bm_o[0] == '0)); // R4
endmodule

// File: rtl/vit_acs.sv
// vit_acs: add-compare-select over all states in one cycle, with normalisation.
// Assumes state = last MEM inputs, newest in bit 0. Ties go to the lower predecessor.
module vit_acs import vit_pkg::*; #(
    parameter int PMW    = 10,
    parameter int BMW    = 5,
    parameter int THRESH = 256,
    parameter int INIT   = 256
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [BMW-1:0]   bm_i [NCW],
    output logic [NST-1:0]   dec_o,
    output logic [MEM-1:0]   best_o
);
    localparam logic [PMW-1:0] LIMIT = PMW'((1 << PMW) - (1 << BMW));

    logic [PMW-1:0] pm_q [NST];
    logic [PMW-1:0] pm_d [NST];
    logic [PMW-1:0] min_v;
    logic [MEM-1:0] min_i;
    logic [PMW-1:0] shave;
    logic           over_any;

    // Find the lowest metric; the lowest index wins a tie.
    always_comb begin
        min_v = pm_q[0];
        min_i = '0;
        for (int s = 1; s < NST; s++) begin
            if (pm_q[s] < min_v) begin
                min_v = pm_q[s];
                min_i = MEM'(s);
            end
        end
    end

    assign shave  = (min_v >= PMW'(THRESH)) ? PMW'(THRESH) : '0;
    assign best_o = min_i;

    for (genvar n = 0; n < NST; n++) begin : g_state
        localparam int P0 = n / 2;
        localparam int P1 = n / 2 + NST / 2;
        localparam logic [NSYM-1:0] CW0 = code_word(P0, (n % 2) == 1);
        localparam logic [NSYM-1:0] CW1 = code_word(P1, (n % 2) == 1);
        logic [PMW-1:0] c0, c1;
        assign c0       = pm_q[P0] + PMW'(bm_i[CW0]);
        assign c1       = pm_q[P1] + PMW'(bm_i[CW1]);
        assign dec_o[n] = (c1 < c0);
        assign pm_d[n]  = (dec_o[n] ? c1 : c0) - shave;
    end

    // Load the starting metrics on reset, else take the survivor metrics.
    always_ff @(posedge clk) begin
        for (int s = 0; s < NST; s++) begin
            if (!rst_n) pm_q[s] <= (s == 0) ? '0 : PMW'(INIT);
            else        pm_q[s] <= pm_d[s];
        end
    end

    // Flag any metric close enough to the top to wrap on the next add.
    always_comb begin
        over_any = 1'b0;
        for (int s = 0; s < NST; s++) if (pm_q[s] >= LIMIT) over_any = 1'b1;
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n) !over_any); // R3
    AST_NORM_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        min_v < PMW'(THRESH + (1 << BMW))); // R3
endmodule

// File: rtl/vit_rex.sv
// vit_rex: register-exchange survivor memory and output selection.
// Assumes dec_i picks, for each state, the upper-half predecessor when set.
module vit_rex import vit_pkg::*; #(
    parameter int DEPTH = 128
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NST-1:0]   dec_i,
    input  logic [MEM-1:0]   best_i,
    output logic             bit_o
);
    logic [DEPTH-1:0] sv_q [NST];

    for (genvar n = 0; n < NST; n++) begin : g_surv
        localparam int   P0  = n / 2;
        localparam int   P1  = n / 2 + NST / 2;
        localparam logic LSB = (n % 2) == 1;
        logic [DEPTH-1:0] src;
        assign src = dec_i[n] ? sv_q[P1] : sv_q[P0];
        // Copy the winner's history, shifted, with this state's input bit appended.
        always_ff @(posedge clk) begin
            if (!rst_n) sv_q[n] <= '0;
            else        sv_q[n] <= {src[DEPTH-2:0], LSB};
        end
    end

    assign bit_o = sv_q[best_i][DEPTH-1];

    AST_SURV_LSB: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (sv_q[NST-1][0] && !sv_q[0][0])); // R1
endmodule

// File: rtl/vit_dec_top.sv
// vit_dec_top: continuous-stream Viterbi decoder, one trellis step per clock.
// Assumes depunctured input with per-symbol keep flags; output lags by DEPTH steps.
module vit_dec_top import vit_pkg::*; #(
    parameter int SW    = 3,
    parameter int DEPTH = 128,
    parameter int PMW   = 10
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NSYM*SW-1:0]   sym_i,
    input  logic [NSYM-1:0]      keep_i,
    output logic                 bit_o,
    output logic                 bit_vld_o
);
    localparam int BMW    = $clog2(NSYM * ((1 << SW) - 1) + 1);
    localparam int THRESH = 1 << (PMW - 2);
    localparam int FW     = $clog2(DEPTH + 1);

    logic [BMW-1:0] bm [NCW];
    logic [NST-1:0] dec;
    logic [MEM-1:0] best;
    logic [FW-1:0]  fill_q;

    vit_bmu #(.SW(SW), .BMW(BMW)) u_bmu (
        .clk(clk), .rst_n(rst_n), .sym_i(sym_i), .keep_i(keep_i), .bm_o(bm)
    );

    vit_acs #(.PMW(PMW), .BMW(BMW), .THRESH(THRESH), .INIT(THRESH)) u_acs (
        .clk(clk), .rst_n(rst_n), .bm_i(bm), .dec_o(dec), .best_o(best)
    );

    vit_rex #(.DEPTH(DEPTH)) u_rex (
        .clk(clk), .rst_n(rst_n), .dec_i(dec), .best_i(best), .bit_o(bit_o)
    );

    // Count processed steps until the survivors span the full depth.
    always_ff @(posedge clk) begin
        if (!rst_n)                     fill_q <= '0;
        else if (fill_q != FW'(DEPTH))  fill_q <= fill_q + FW'(1);
    end

    assign bit_vld_o = (fill_q == FW'(DEPTH));

    AST_VALID_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        bit_vld_o |=> bit_vld_o); // R2
    AST_RESET_CLEAR: assert property (@(posedge clk)
        !rst_n |=> !bit_vld_o); // R6
endmodule

// File: tb/sim_vit_dec_top.sv
// Scoreboard bench: the driver encodes and queues each information bit, the monitor
// pops and compares whenever the decoder reports a valid bit.
module sim_vit_dec_top;
    localparam int SW = 3, DEPTH = 128, NS = 4, MB = 6;
    localparam logic [6:0] G_TB [NS] = '{7'o117, 7'o127, 7'o155, 7'o171};

    logic clk = 1'b0, rst_n = 1'b0;
    logic [NS*SW-1:0] sym = '0;
    logic [NS-1:0]    keep = '0;
    logic bit_o, vld;

    vit_dec_top u0 (.clk(clk), .rst_n(rst_n), .sym_i(sym), .keep_i(keep),
                    .bit_o(bit_o), .bit_vld_o(vld));

    always #2 clk = ~clk;

    typedef struct { logic b; string tag; } item_t;
    item_t exp_q[$];
    int checks = 0, errors = 0, steps = -1, nstep = 0;
    logic [MB-1:0] enc_st = '0;

    always @(posedge clk) steps <= !rst_n ? 0 : steps + 1;

    // Monitor: valid timing every cycle (R2, R6 under reset), decoded bit when valid.
    always @(negedge clk) begin
        if (steps >= 0) begin
            checks++;
            if (vld !== (steps >= DEPTH)) begin
                errors++;
                $display("FAIL %s valid: got %b expected %b", rst_n ? "R2" : "R6", vld, steps >= DEPTH);
            end
            if (vld === 1'b1) begin
                checks++;
                if (exp_q.size() == 0) begin
                    errors++;
                    $display("FAIL R2 output valid with empty scoreboard: got %b expected none", bit_o);
                end else begin
                    item_t it;
                    it = exp_q.pop_front();
                    if (bit_o !== it.b) begin
                        errors++;
                        $display("FAIL %s decoded bit: got %b expected %b", it.tag, bit_o, it.b);
                    end
                end
            end
        end
    end

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    // Driver: encode one step, shape symbols by mode, queue the expected bit.
    task automatic step(input logic u, input int md, input string tag);
        logic [6:0] rv;
        logic e;
        int r;
        rv = {enc_st, u};
        for (int j = 0; j < NS; j++) begin
            e = ^(G_TB[j] & rv);
            keep[j] = 1'b1;
            case (md)
                0: r = e ? 7 : 0;
                1: begin keep[j] = (j == 0) || (j == 1 && nstep % 8 == 0); r = e ? 7 : 0; end
                2: begin keep[j] = (j < 2); r = e ? 7 - int'($urandom % 3) : int'($urandom % 3); end
                default: r = (j == 2 && nstep % 16 == 5) ? (e ? 0 : 7)
                                                         : (e ? 7 - int'($urandom % 3) : int'($urandom % 3));
            endcase
            if (!keep[j]) r = int'($urandom % 8);
            sym[j*SW +: SW] = SW'(r);
        end
        enc_st = {enc_st[MB-2:0], u};
        nstep++;
        exp_q.push_back('{u, tag});
    endtask

    // Run n steps; pat 0 random, 1 all ones, 2 alternating.
    task automatic run(input int n, input int pat, input int md, input string tag);
        for (int i = 0; i < n; i++) begin
            logic u;
            case (pat)
                0: u = 1'($urandom % 2);
                1: u = 1'b1;
                default: u = 1'(i % 2);
            endcase
            step(u, md, tag);
            @(posedge clk); #1;
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        run(300, 0, 0, "R1");
        run(200, 1, 0, "R1");
        run(150, 2, 0, "R1");
        run(400, 0, 1, "R4");
        run(400, 0, 2, "R5");
        run(1500, 0, 3, "R3 R7");
        rst_n = 1'b0;
        @(posedge clk); #1;
        exp_q.delete();
        enc_st = '0;
        nstep = 0;
        repeat (2) @(posedge clk);
        #1 rst_n = 1'b1;
        run(300, 0, 0, "R6");
        @(negedge clk); #1;
        summary();
        $finish;
    end

    initial begin
        #(4 * 200000);
        checks++;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        summary();
        $finish;
    end
endmodule